// File: doc/BRIEF.md
# SMBus Process Call Master Sequencer

This block is a bus master that runs one SMBus process call on a pair of open-drain lines. Software sets up a 7-bit target address, a command byte, a 16-bit word to write and a checksum enable, then pulses a start request. The block then does the whole exchange with no further help. It writes the address, the command and the word. It turns the bus round with a repeated start. It reads a 16-bit word back and, when checking is enabled, a trailing checksum byte that it compares against its own CRC-8 of the whole exchange.

Bit timing comes from a programmable divider of the system clock. Each bit slot has four equal quarters. SCL is held low for the first two quarters and released for the last two. The data line is set up while SCL is low. It moves while SCL is high only to form a start, repeated start or stop. The block reports the result with a one-cycle done pulse, the received word, a NACK flag and a checksum mismatch flag. A missing acknowledge from the target ends the exchange early with a stop.

Top module: `smbus_pcall_master`

## Requirements
- R1: After reset both line drivers are released (sclDriveLow and sdaDriveLow are 0), busy, done, nackErr and pecErr are 0, and rdWord is 0.
- R2: The exchange opens with a start condition in slot 1. The master then sends four bytes, most significant bit first: {tgtAddr, 0} in slots 2-9, cmdByte in slots 11-18, wrWord[7:0] in slots 20-27 and wrWord[15:8] in slots 29-36. It releases SDA in slots 10, 19, 28 and 37 so the target can acknowledge.
- R3: In slot 38 the master forms a repeated start: SDA falls while SCL is high. It then sends {tgtAddr, 1} in slots 39-46 and releases SDA in slot 47 for the target's acknowledge.
- R4: The target's first read byte (slots 48-55) becomes rdWord[7:0] and its second (slots 57-64) becomes rdWord[15:8]. The master pulls SDA low in slot 56 to acknowledge the first byte.
- R5: With pecOn low, the master releases SDA in slot 65 (not-acknowledge) and makes a stop in slot 66. The exchange has exactly 66 SCL pulses.
- R6: With pecOn high, the master pulls SDA low in slot 65 and reads a checksum byte in slots 66-73. It releases SDA in slot 74 and makes a stop in slot 75, for exactly 75 SCL pulses.
- R7: The checksum is CRC-8 with polynomial 0x07 and initial value 0, processed most significant bit first. It covers both address bytes, the command, both written bytes and both read bytes, and no acknowledge bits. A received checksum that differs sets pecErr, and the exchange still ends with the not-acknowledge in slot 74 and the stop in slot 75. A matching checksum leaves pecErr at 0.
- R8: If SDA is high in any slot where the target should acknowledge, the next slot is a stop, nackErr is set and done still pulses.
- R9: SDA changes while SCL is high only for the start, the repeated start and the stop.
- R10: SCL stays low for 2*(divCount+1) clock cycles and high for 2*(divCount+1) clock cycles in each slot.
- R11: busy is high from the cycle after an accepted startReq until the stop ends. done is high for exactly one cycle at that point, and busy is low in that cycle.
- R12: A startReq while busy is ignored. Changes to tgtAddr, cmdByte, wrWord and pecOn after acceptance do not alter the exchange in progress, and no second exchange follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Pulse to begin an exchange; taken only when idle |
| tgtAddr | input | 7 | Target address |
| cmdByte | input | 8 | Command code sent after the write address |
| wrWord | input | 16 | Word written, low byte first |
| pecOn | input | 1 | Enables checksum read and compare |
| divCount | input | DIV_W | Quarter-slot length minus one, in clock cycles |
| sdaIn | input | 1 | Sensed level of the data line |
| sclDriveLow | output | 1 | Pulls the clock line low when 1 |
| sdaDriveLow | output | 1 | Pulls the data line low when 1 |
| busy | output | 1 | An exchange is in progress |
| done | output | 1 | One-cycle pulse when the stop completes |
| nackErr | output | 1 | The target failed to acknowledge in the last exchange |
| pecErr | output | 1 | The checksum mismatched in the last exchange |
| rdWord | output | 16 | Word read from the target |

## Verification
The assertions assume that divCount stays constant while busy is high and that the sensed data line only changes while SCL is held low. Without these, neither the slot-length nor the line-ordering properties would be meaningful. The bench target model meets both. It drives its acknowledge and read bits only at the falling SCL edge it sees, and it releases the line at the next falling edge. The bench writes divCount only between exchanges. After an injected NACK, the model stops driving, so that the early stop is seen on a free line.

// File: rtl/pcall_pkg.sv
package pcall_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;

  // what the data line shows during a slot
  typedef enum logic [2:0] {
    SRC_REL,
    SRC_LOW,
    SRC_TX,
    SRC_START,
    SRC_STOP
  } sdaSrcT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TX,
    ST_RACK,
    ST_RSTART,
    ST_RX,
    ST_MACK,
    ST_STOP
  } stateT;

  typedef struct packed {
    logic   launch;
    logic   run;
    sdaSrcT sdaSrc;
    logic   loadTx;
    logic [2:0] txSel;
    logic   shiftTx;
    logic   shiftRx;
    logic   crcTx;
    logic   crcRx;
    logic   storeLo;
    logic   storeHi;
    logic   checkPec;
  } strobeT;
endpackage

// File: rtl/pcall_datapath.sv
module pcall_datapath
  import pcall_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strb,
  input  logic [DIV_W-1:0]    divCount,
  input  logic [ADDR_W-1:0]   tgtAddr,
  input  logic [BYTE_W-1:0]   cmdByte,
  input  logic [WORD_W-1:0]   wrWord,
  input  logic                sdaIn,
  output logic                slotEnd,
  output logic                sampledBit,
  output logic                sclDriveLow,
  output logic                sdaDriveLow,
  output logic [WORD_W-1:0]   rdWord,
  output logic                pecErr
);
  localparam int NUM_Q = 4;
  localparam logic [1:0] LAST_Q = 2'(NUM_Q - 1);
  localparam logic [1:0] SAMPLE_Q = 2'd2;

  logic [DIV_W-1:0]  divCnt;
  logic [1:0]        quarter;
  logic              qEnd;
  logic [ADDR_W-1:0] addrQ;
  logic [BYTE_W-1:0] cmdQ;
  logic [WORD_W-1:0] wrQ;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] crc;
  logic [BYTE_W-1:0] rdLo;
  logic [BYTE_W-1:0] rdHi;
  logic              sclRel;
  logic              sdaRel;
  logic              lvlA;
  logic              lvlB;

  function automatic logic [BYTE_W-1:0] crcStep(input logic [BYTE_W-1:0] c, input logic b);
    logic fb;
    fb = c[BYTE_W-1] ^ b;
    return {c[BYTE_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  // quarter-slot timing
  assign qEnd    = strb.run && (divCnt == divCount);
  assign slotEnd = qEnd && (quarter == LAST_Q);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      quarter <= '0;
    end else if (!strb.run) begin
      divCnt  <= '0;
      quarter <= '0;
    end else if (qEnd) begin
      divCnt  <= '0;
      quarter <= quarter + 2'd1;
    end else begin
      divCnt  <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampledBit <= 1'b1;
    else if (qEnd && quarter == SAMPLE_Q) sampledBit <= sdaIn;
  end

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      cmdQ  <= '0;
      wrQ   <= '0;
    end else if (strb.launch) begin
      addrQ <= tgtAddr;
      cmdQ  <= cmdByte;
      wrQ   <= wrWord;
    end
  end

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (strb.loadTx) begin
      case (strb.txSel)
        3'd0:    txShift <= {addrQ, 1'b0};
        3'd1:    txShift <= cmdQ;
        3'd2:    txShift <= wrQ[BYTE_W-1:0];
        3'd3:    txShift <= wrQ[WORD_W-1:BYTE_W];
        default: txShift <= {addrQ, 1'b1};
      endcase
    end else if (strb.shiftTx) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  // receive shifter and result word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rdLo    <= '0;
      rdHi    <= '0;
    end else begin
      if (strb.shiftRx) rxShift <= {rxShift[BYTE_W-2:0], sampledBit};
      if (strb.storeLo) rdLo <= rxShift;
      if (strb.storeHi) rdHi <= rxShift;
    end
  end

  assign rdWord = {rdHi, rdLo};

  // running checksum and compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crc    <= '0;
      pecErr <= 1'b0;
    end else if (strb.launch) begin
      crc    <= '0;
      pecErr <= 1'b0;
    end else begin
      if (strb.crcTx) crc <= crcStep(crc, txShift[BYTE_W-1]);
      else if (strb.crcRx) crc <= crcStep(crc, sampledBit);
      if (strb.checkPec) pecErr <= (rxShift != crc);
    end
  end

  // line levels: A in quarters 1-2, B in quarter 3, held in quarter 0
  always_comb begin
    case (strb.sdaSrc)
      SRC_LOW:   begin lvlA = 1'b0;              lvlB = 1'b0;              end
      SRC_TX:    begin lvlA = txShift[BYTE_W-1]; lvlB = txShift[BYTE_W-1]; end
      SRC_START: begin lvlA = 1'b1;              lvlB = 1'b0;              end
      SRC_STOP:  begin lvlA = 1'b0;              lvlB = 1'b1;              end
      default:   begin lvlA = 1'b1;              lvlB = 1'b1;              end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclRel <= 1'b1;
      sdaRel <= 1'b1;
    end else begin
      sclRel <= !strb.run || quarter[1];
      if (!strb.run) sdaRel <= 1'b1;
      else begin
        case (quarter)
          2'd0:    sdaRel <= sdaRel;
          LAST_Q:  sdaRel <= lvlB;
          default: sdaRel <= lvlA;
        endcase
      end
    end
  end

  assign sclDriveLow = !sclRel;
  assign sdaDriveLow = !sdaRel;

  // R9: data moves under a high clock only for start-type or stop slots
  assert_sda_while_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((sdaRel != $past(sdaRel)) && sclRel && $past(sclRel))
      |-> ($past(strb.sdaSrc) == SRC_START || $past(strb.sdaSrc) == SRC_STOP));

  // R1: lines are free whenever no exchange runs
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |-> (sclRel && sdaRel));

  // R10: the quarter counter never runs past the programmed length
  assert_div_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (divCnt <= divCount));
endmodule

// File: rtl/pcall_ctrl.sv
module pcall_ctrl
  import pcall_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   pecOn,
  input  logic   slotEnd,
  input  logic   sampledBit,
  output strobeT strb,
  output logic   busy,
  output logic   done,
  output logic   nackErr
);
  localparam logic [2:0] TX_HI_IDX = 3'd3;
  localparam logic [2:0] TX_RD_IDX = 3'd4;
  localparam int SLOT_W = 7;
  localparam logic [SLOT_W-1:0] LEN_PLAIN = SLOT_W'(65);
  localparam logic [SLOT_W-1:0] LEN_PEC   = SLOT_W'(74);

  stateT             state;
  logic [2:0]        bitCnt;
  logic [2:0]        txIdx;
  logic [1:0]        rxIdx;
  logic              pecQ;
  logic [SLOT_W-1:0] slotCnt;
  logic              byteDone;
  logic              ackLow;
  logic              lastRead;

  assign byteDone = (bitCnt == 3'd7);
  assign ackLow   = (rxIdx == 2'd0) || (rxIdx == 2'd1 && pecQ);
  assign lastRead = (rxIdx == 2'd1 && !pecQ) || (rxIdx == 2'd2);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb        = '0;
    strb.run    = (state != ST_IDLE);
    strb.launch = (state == ST_IDLE) && startReq;
    case (state)
      ST_START:  strb.sdaSrc = SRC_START;
      ST_RSTART: strb.sdaSrc = SRC_START;
      ST_STOP:   strb.sdaSrc = SRC_STOP;
      ST_TX:     strb.sdaSrc = SRC_TX;
      ST_MACK:   strb.sdaSrc = ackLow ? SRC_LOW : SRC_REL;
      default:   strb.sdaSrc = SRC_REL;
    endcase
    if (slotEnd) begin
      case (state)
        ST_START: begin
          strb.loadTx = 1'b1;
          strb.txSel  = 3'd0;
        end
        ST_TX: begin
          strb.shiftTx = 1'b1;
          strb.crcTx   = 1'b1;
        end
        ST_RACK: begin
          if (!sampledBit && txIdx < TX_HI_IDX) begin
            strb.loadTx = 1'b1;
            strb.txSel  = txIdx + 3'd1;
          end
        end
        ST_RSTART: begin
          strb.loadTx = 1'b1;
          strb.txSel  = TX_RD_IDX;
        end
        ST_RX: begin
          strb.shiftRx = 1'b1;
          strb.crcRx   = (rxIdx != 2'd2);
        end
        ST_MACK: begin
          strb.storeLo  = (rxIdx == 2'd0);
          strb.storeHi  = (rxIdx == 2'd1);
          strb.checkPec = (rxIdx == 2'd2);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      txIdx   <= '0;
      rxIdx   <= '0;
      pecQ    <= 1'b0;
      nackErr <= 1'b0;
      slotCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.launch) begin
        state   <= ST_START;
        pecQ    <= pecOn;
        nackErr <= 1'b0;
        slotCnt <= '0;
        txIdx   <= '0;
        rxIdx   <= '0;
        bitCnt  <= '0;
      end else if (slotEnd) begin
        slotCnt <= slotCnt + 1'b1;
        case (state)
          ST_START: begin
            state  <= ST_TX;
            txIdx  <= '0;
            bitCnt <= '0;
          end
          ST_TX: begin
            bitCnt <= bitCnt + 3'd1;
            if (byteDone) state <= ST_RACK;
          end
          ST_RACK: begin
            if (sampledBit) begin
              nackErr <= 1'b1;
              state   <= ST_STOP;
            end else if (txIdx == TX_HI_IDX) begin
              state <= ST_RSTART;
            end else if (txIdx == TX_RD_IDX) begin
              state  <= ST_RX;
              bitCnt <= '0;
            end else begin
              txIdx <= txIdx + 3'd1;
              state <= ST_TX;
            end
          end
          ST_RSTART: begin
            txIdx <= TX_RD_IDX;
            state <= ST_TX;
          end
          ST_RX: begin
            bitCnt <= bitCnt + 3'd1;
            if (byteDone) state <= ST_MACK;
          end
          ST_MACK: begin
            if (lastRead) state <= ST_STOP;
            else begin
              rxIdx <= rxIdx + 2'd1;
              state <= ST_RX;
            end
          end
          ST_STOP: begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R11: completion strobe lasts a single cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: a high acknowledge slot leads straight to stop with the flag raised
  assert_nack_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && slotEnd && sampledBit) |=> (state == ST_STOP && nackErr));

  // R5: a full plain exchange ends after 66 slots
  assert_len_plain_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && slotEnd && !nackErr && !pecQ) |-> (slotCnt == LEN_PLAIN));

  // R6: a full checked exchange ends after 75 slots
  assert_len_pec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && slotEnd && !nackErr && pecQ) |-> (slotCnt == LEN_PEC));

  // R12: a request during an exchange does not disturb the captured mode
  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> $stable(pecQ));
endmodule

// File: rtl/smbus_pcall_master.sv
module smbus_pcall_master
  import pcall_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic [WORD_W-1:0] wrWord,
  input  logic              pecOn,
  input  logic [DIV_W-1:0]  divCount,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              busy,
  output logic              done,
  output logic              nackErr,
  output logic              pecErr,
  output logic [WORD_W-1:0] rdWord
);
  strobeT strb;
  logic   slotEnd;
  logic   sampledBit;

  pcall_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .pecOn      (pecOn),
    .slotEnd    (slotEnd),
    .sampledBit (sampledBit),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .nackErr    (nackErr)
  );

  pcall_datapath #(.DIV_W(DIV_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .divCount    (divCount),
    .tgtAddr     (tgtAddr),
    .cmdByte     (cmdByte),
    .wrWord      (wrWord),
    .sdaIn       (sdaIn),
    .slotEnd     (slotEnd),
    .sampledBit  (sampledBit),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow),
    .rdWord      (rdWord),
    .pecErr      (pecErr)
  );
endmodule

// File: tb/sim_smbus_pcall_master.sv
`timescale 1ns/1ps
module sim_smbus_pcall_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [6:0]  tgtAddr = '0;
  logic [7:0]  cmdByte = '0;
  logic [15:0] wrWord = '0;
  logic        pecOn = 1'b0;
  logic [7:0]  divCount = 8'd3;
  logic        sdaIn;
  logic        sclDriveLow, sdaDriveLow, busy, done, nackErr, pecErr;
  logic [15:0] rdWord;
  logic        slaveLow = 1'b0;

  always #4 clk = ~clk;

  assign sdaIn = !(sdaDriveLow || slaveLow);

  smbus_pcall_master u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tgtAddr(tgtAddr),
    .cmdByte(cmdByte), .wrWord(wrWord), .pecOn(pecOn), .divCount(divCount),
    .sdaIn(sdaIn), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .busy(busy), .done(done), .nackErr(nackErr), .pecErr(pecErr), .rdWord(rdWord)
  );

  int nChecks = 0;
  int nErr = 0;

  // expected transaction parameters
  logic [6:0]  eAddr;
  logic [7:0]  eCmd, eLo, eHi, ePec;
  logic [15:0] eWr;
  bit          ePecOn;
  int          nackSlot;
  bit          gotDone;

  // bus monitor state
  logic bits [1:100];
  int   nRise, starts, stops, stopK, cyc, riseAt, fallAt, highLen, lowLen;
  int   startK [0:3];
  logic prevScl = 1'b1;
  logic prevSda = 1'b1;

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crcByte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  // level the target leaves on SDA in slot n (1 = released)
  function automatic logic slaveBit(input int n);
    if (nackSlot != 0 && n > nackSlot) return 1'b1;
    if (n == 10 || n == 19 || n == 28 || n == 37 || n == 47) return (n == nackSlot);
    if (n >= 48 && n <= 55) return eLo[55 - n];
    if (n >= 57 && n <= 64) return eHi[64 - n];
    if (ePecOn && n >= 66 && n <= 73) return ePec[73 - n];
    return 1'b1;
  endfunction

  function automatic logic [7:0] getByte(input int s);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7 - i] = bits[s + i];
    return b;
  endfunction

  always @(negedge clk) begin
    logic curScl, curSda;
    curScl = !sclDriveLow;
    curSda = sdaIn;
    cyc++;
    if (!prevScl && curScl) begin
      nRise++;
      if (nRise <= 100) bits[nRise] = curSda;
      lowLen = cyc - fallAt;
      riseAt = cyc;
    end
    if (prevScl && curScl && prevSda && !curSda) begin
      if (starts < 4) startK[starts] = nRise;
      starts++;
    end
    if (prevScl && curScl && !prevSda && curSda) begin
      stops++;
      stopK = nRise;
    end
    prevScl = curScl;
    prevSda = curSda;
    if (prevScl == 1'b0 && fallAt != cyc && !curScl && riseAt >= fallAt) begin
      highLen = cyc - riseAt;
      fallAt  = cyc;
      slaveLow = !slaveBit(nRise + 1);
    end
  end

  task automatic runTxn(input logic [6:0] a, input logic [7:0] c, input logic [15:0] w,
                        input bit p, input logic [7:0] lo, input logic [7:0] hi,
                        input bit badPec, input int nk, input logic [7:0] dv, input bit poke);
    logic [7:0] crc;
    eAddr = a; eCmd = c; eWr = w; ePecOn = p; eLo = lo; eHi = hi; nackSlot = nk;
    crc = 8'h00;
    crc = crcByte(crc, {a, 1'b0});
    crc = crcByte(crc, c);
    crc = crcByte(crc, w[7:0]);
    crc = crcByte(crc, w[15:8]);
    crc = crcByte(crc, {a, 1'b1});
    crc = crcByte(crc, lo);
    crc = crcByte(crc, hi);
    ePec = badPec ? (crc ^ 8'h5A) : crc;
    @(negedge clk);
    nRise = 0; starts = 0; stops = 0; stopK = 0;
    for (int i = 0; i < 4; i++) startK[i] = 0;
    divCount = dv; tgtAddr = a; cmdByte = c; wrWord = w; pecOn = p;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chkEq("R11 busy after accepted start", busy, 1);
    gotDone = 0;
    for (int t = 0; t < 20000; t++) begin
      if (poke && t == 150) begin
        startReq = 1'b1; tgtAddr = 7'h7F; cmdByte = 8'h00; wrWord = 16'hFFFF; pecOn = !p;
      end else begin
        startReq = 1'b0;
      end
      @(negedge clk);
      if (done) begin gotDone = 1; break; end
    end
    startReq = 1'b0;
    chkEq("R11 done pulse seen", gotDone, 1);
    chkEq("R11 busy low with done", busy, 0);
    @(negedge clk);
    chkEq("R11 done lasts one cycle", done, 0);
  endtask

  task automatic checkWrite();
    chkEq("R2 start in slot 1", startK[0], 1);
    chkEq("R2 write address byte", getByte(2), {eAddr, 1'b0});
    chkEq("R2 command byte", getByte(11), eCmd);
    chkEq("R2 low write byte", getByte(20), eWr[7:0]);
    chkEq("R2 high write byte", getByte(29), eWr[15:8]);
    chkEq("R2 ack slots low", {bits[10], bits[19], bits[28], bits[37]}, 4'b0000);
  endtask

  task automatic checkRead();
    chkEq("R3 repeated start slot", startK[1], 38);
    chkEq("R3 read address byte", getByte(39), {eAddr, 1'b1});
    chkEq("R4 master ack after low byte", bits[56], 0);
    chkEq("R4 received word", rdWord, {eHi, eLo});
  endtask

  task automatic testReset();
    chkEq("R1 scl released", sclDriveLow, 0);
    chkEq("R1 sda released", sdaDriveLow, 0);
    chkEq("R1 busy", busy, 0);
    chkEq("R1 done", done, 0);
    chkEq("R1 flags", {nackErr, pecErr}, 2'b00);
    chkEq("R1 rdWord", rdWord, 16'h0000);
  endtask

  task automatic testPlain();
    runTxn(7'h2C, 8'hA5, 16'h1234, 0, 8'h9E, 8'h01, 0, 0, 8'd3, 0);
    checkWrite();
    checkRead();
    chkEq("R5 nack on high read byte", bits[65], 1);
    chkEq("R5 pulse count", nRise, 66);
    chkEq("R5 stop slot", stopK, 66);
    chkEq("R9 starts under high clock", starts, 2);
    chkEq("R9 stops under high clock", stops, 1);
    chkEq("R7 no pec error when off", pecErr, 0);
    chkEq("R8 no nack", nackErr, 0);
    chkEq("R10 high length div 3", highLen, 8);
    chkEq("R10 low length div 3", lowLen, 8);
  endtask

  task automatic testPec();
    runTxn(7'h51, 8'h3C, 16'hBEEF, 1, 8'h77, 8'hC4, 0, 0, 8'd2, 0);
    checkWrite();
    checkRead();
    chkEq("R6 ack on high read byte", bits[65], 0);
    chkEq("R6 nack after pec", bits[74], 1);
    chkEq("R6 pulse count", nRise, 75);
    chkEq("R6 stop slot", stopK, 75);
    chkEq("R7 matching pec clean", pecErr, 0);
  endtask

  task automatic testPecBad();
    runTxn(7'h0A, 8'h80, 16'h00FF, 1, 8'h00, 8'hFF, 1, 0, 8'd1, 0);
    chkEq("R7 mismatch sets pecErr", pecErr, 1);
    chkEq("R7 still nack after pec", bits[74], 1);
    chkEq("R7 still ends at slot 75", stopK, 75);
    chkEq("R7 word still stored", rdWord, 16'hFF00);
    runTxn(7'h0A, 8'h80, 16'h00FF, 1, 8'h00, 8'hFF, 0, 0, 8'd1, 0);
    chkEq("R7 pecErr cleared by next good run", pecErr, 0);
  endtask

  task automatic testNack();
    runTxn(7'h33, 8'h11, 16'h2222, 0, 8'h44, 8'h55, 0, 19, 8'd2, 0);
    chkEq("R8 nackErr after command nack", nackErr, 1);
    chkEq("R8 stop right after nack", stopK, 20);
    chkEq("R8 pulse count after abort", nRise, 20);
    runTxn(7'h33, 8'h11, 16'h2222, 1, 8'h44, 8'h55, 0, 47, 8'd2, 0);
    chkEq("R8 nackErr after read address nack", nackErr, 1);
    chkEq("R8 stop after read address nack", stopK, 48);
    chkEq("R8 one repeated start only", starts, 2);
  endtask

  task automatic testBusy();
    runTxn(7'h6E, 8'h5B, 16'hA1C3, 0, 8'h3D, 8'h92, 0, 0, 8'd3, 1);
    checkWrite();
    checkRead();
    chkEq("R12 plain length kept", nRise, 66);
    repeat (40) @(negedge clk);
    chkEq("R12 no second exchange", busy, 0);
    chkEq("R12 bus quiet afterwards", nRise, 66);
  endtask

  task automatic testDivider();
    runTxn(7'h12, 8'h34, 16'h5678, 0, 8'hAB, 8'hCD, 0, 0, 8'd0, 0);
    chkEq("R10 high length div 0", highLen, 2);
    chkEq("R10 low length div 0", lowLen, 2);
    chkEq("R4 word at div 0", rdWord, 16'hCDAB);
    runTxn(7'h12, 8'h34, 16'h5678, 1, 8'hAB, 8'hCD, 0, 0, 8'd5, 0);
    chkEq("R10 high length div 5", highLen, 12);
    chkEq("R10 low length div 5", lowLen, 12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    nChecks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    cyc = 0; riseAt = 0; fallAt = 0; highLen = 0; lowLen = 0;
    nRise = 0; starts = 0; stops = 0; stopK = 0; nackSlot = 0; ePecOn = 0;
    eLo = '0; eHi = '0; ePec = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlain();
    testPec();
    testPecBad();
    testNack();
    testBusy();
    testDivider();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule